// File: doc/BRIEF.md
# VLAN Table Command Engine

This block keeps a small table of VLAN entries, each holding a VLAN identifier, a port membership mask and a valid flag. Software reaches it over a two-register bus. It places the membership for the next load in the data register. It then writes the command register with the start bit set to run one of four table operations: flush, load, purge or remove-port. The engine walks the table one entry per clock and drops its busy bit when the operation is done. It also raises a full flag when a load finds neither a matching entry nor a free one.

A separate lookup port takes a VLAN identifier and returns, one clock later, whether a valid entry holds it and that entry's member mask. Forwarding logic uses this port while software keeps the table up to date through the register bus. Loads keep each identifier unique within the table, so a lookup never has two candidates.

Top module: `vlan_cmd_engine`

## Requirements
- R1: After reset every entry is invalid, both registers read as zero, busy (command bit 3) and full (command bit 4) are clear, and every lookup misses.
- R2: Register address 0 is the command register: bits [2:0] operation (0 no-op, 1 flush, 2 load, 3 purge, 4 remove-port), bit 3 busy, bit 4 full, bits [11:8] port, bits [27:16] VLAN identifier, bits [30:28] priority, bit 31 priority enable. A write with bit 3 set while idle latches the fields and starts the operation. A write with bit 3 clear while idle changes nothing. Unused bits read as zero.
- R3: Register address 1 is the data register: bits [9:0] member mask and bit 11 valid are stored and read back, and all other bits read as zero.
- R4: While busy, writes to either register are ignored.
- R5: Flush invalidates every entry and keeps busy set for exactly 16 clocks.
- R6: A load whose identifier matches the valid entry at index i replaces that entry's member mask with the data register mask and keeps busy set for i+1 clocks.
- R7: A load with no matching entry writes the identifier and mask into the lowest-indexed invalid entry and keeps busy set for 17 clocks.
- R8: A load with no match and no invalid entry leaves the table unchanged, keeps busy set for 17 clocks and sets full. Full is cleared when the next command starts.
- R9: Purge invalidates the valid entry that matches the identifier at index i, with busy set for i+1 clocks. With no match the table is unchanged and busy lasts 16 clocks.
- R10: Remove-port clears the given port's bit in every entry's mask, with busy set for 16 clocks. A port number of 10 or more leaves the table unchanged.
- R11: No-op and the undefined operation codes 5 to 7 keep busy set for one clock and leave the table unchanged.
- R12: The lookup outputs update on the clock after lookup_vid is applied. They reflect the table as it stood before any table write at that same edge. A miss returns a zero mask.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 command, 1 data |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register (combinational) |
| lookup_vid | input | 12 | Identifier to search for |
| lookup_hit | output | 1 | A valid entry holds the identifier (registered) |
| lookup_members | output | 10 | Member mask of the hit entry, zero on miss (registered) |

## Verification
The lookup port and the command walker both touch the table at the same clock edge. A lookup can therefore sample an entry in the very cycle that a purge, load or remove-port rewrites it. The bench provokes this by holding lookup_vid on an identifier while a purge removes that identifier from slot 0. The first lookup result, taken at the edge where the entry is cleared, must still report the old membership, and the following result must report a miss. Register writes that arrive during a walk are a second overlap: they are issued in the middle of a 16-clock operation and judged by reading both registers back afterwards.

// File: rtl/vce_pkg.sv
package vce_pkg;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_WALK   = 2'd1,
      ST_COMMIT = 2'd2
   } vce_state_e;

   localparam logic [2:0] OP_NOP    = 3'd0;
   localparam logic [2:0] OP_FLUSH  = 3'd1;
   localparam logic [2:0] OP_LOAD   = 3'd2;
   localparam logic [2:0] OP_PURGE  = 3'd3;
   localparam logic [2:0] OP_RMPORT = 3'd4;

   localparam int CMD_OP_LSB    = 0;
   localparam int CMD_BUSY_BIT  = 3;
   localparam int CMD_FULL_BIT  = 4;
   localparam int CMD_PORT_LSB  = 8;
   localparam int CMD_VID_LSB   = 16;
   localparam int CMD_PRIO_LSB  = 28;
   localparam int CMD_PRIOE_BIT = 31;

   localparam int DAT_MEMB_LSB  = 0;
   localparam int DAT_VALID_BIT = 11;

endpackage

// File: rtl/vce_regs.sv
module vce_regs
   import vce_pkg::*;
#(
   parameter int VID_W  = 12,
   parameter int MEMB_W = 10,
   parameter int PORT_W = 4,
   parameter int PRIO_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_addr,
   input  logic [31:0]       reg_wdata,
   input  logic              busy,
   input  logic              full,
   output logic [31:0]       reg_rdata,
   output logic              start,
   output logic [2:0]        cmd_op,
   output logic [PORT_W-1:0] cmd_port,
   output logic [VID_W-1:0]  cmd_vid,
   output logic [MEMB_W-1:0] data_memb
);

   localparam logic [31:0] CMD_KEEP =
        (32'h7 << CMD_OP_LSB)
      | (((32'd1 << PORT_W) - 32'd1) << CMD_PORT_LSB)
      | (((32'd1 << VID_W)  - 32'd1) << CMD_VID_LSB)
      | (((32'd1 << PRIO_W) - 32'd1) << CMD_PRIO_LSB)
      | (32'd1 << CMD_PRIOE_BIT);

   localparam logic [31:0] DAT_KEEP =
        (((32'd1 << MEMB_W) - 32'd1) << DAT_MEMB_LSB)
      | (32'd1 << DAT_VALID_BIT);

   logic [31:0] cmd_q;
   logic [31:0] dat_q;
   logic        wr_cmd;
   logic        wr_dat;
   logic [31:0] cmd_view;
   logic [31:0] dat_view;

   assign wr_cmd = reg_wr && !reg_addr && !busy;
   assign wr_dat = reg_wr &&  reg_addr && !busy;
   assign start  = wr_cmd && reg_wdata[CMD_BUSY_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q <= '0;
         dat_q <= '0;
      end else begin
         if (start)  cmd_q <= reg_wdata;
         if (wr_dat) dat_q <= reg_wdata;
      end
   end

   assign cmd_op    = cmd_q[CMD_OP_LSB +: 3];
   assign cmd_port  = cmd_q[CMD_PORT_LSB +: PORT_W];
   assign cmd_vid   = cmd_q[CMD_VID_LSB +: VID_W];
   assign data_memb = dat_q[DAT_MEMB_LSB +: MEMB_W];

   always_comb begin
      cmd_view               = cmd_q & CMD_KEEP;
      cmd_view[CMD_BUSY_BIT] = busy;
      cmd_view[CMD_FULL_BIT] = full;
      dat_view               = dat_q & DAT_KEEP;
      reg_rdata              = reg_addr ? dat_view : cmd_view;
   end

endmodule

// File: rtl/vce_table.sv
module vce_table #(
   parameter int DEPTH  = 16,
   parameter int VID_W  = 12,
   parameter int MEMB_W = 10,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic              wr_valid,
   input  logic [VID_W-1:0]  wr_vid,
   input  logic [MEMB_W-1:0] wr_memb,
   output logic [DEPTH-1:0]  ent_valid,
   output logic [VID_W-1:0]  ent_vid  [DEPTH],
   output logic [MEMB_W-1:0] ent_memb [DEPTH]
);

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      logic sel;
      assign sel = wr_en && (wr_idx == IDX_W'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ent_valid[g] <= 1'b0;
            ent_vid[g]   <= '0;
            ent_memb[g]  <= '0;
         end else if (sel) begin
            ent_valid[g] <= wr_valid;
            ent_vid[g]   <= wr_vid;
            ent_memb[g]  <= wr_memb;
         end
      end
   end

endmodule

// File: rtl/vce_walker.sv
module vce_walker
   import vce_pkg::*;
#(
   parameter int DEPTH  = 16,
   parameter int VID_W  = 12,
   parameter int MEMB_W = 10,
   parameter int PORT_W = 4,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [2:0]        cmd_op,
   input  logic [PORT_W-1:0] cmd_port,
   input  logic [VID_W-1:0]  cmd_vid,
   input  logic [MEMB_W-1:0] data_memb,
   input  logic [DEPTH-1:0]  ent_valid,
   input  logic [VID_W-1:0]  ent_vid  [DEPTH],
   input  logic [MEMB_W-1:0] ent_memb [DEPTH],
   output logic              wr_en,
   output logic [IDX_W-1:0]  wr_idx,
   output logic              wr_valid,
   output logic [VID_W-1:0]  wr_vid,
   output logic [MEMB_W-1:0] wr_memb,
   output logic              busy,
   output logic              full
);

   localparam logic [IDX_W-1:0]  LAST_IDX = IDX_W'(DEPTH - 1);
   localparam logic [PORT_W:0]   PORT_LIM = (PORT_W + 1)'(MEMB_W);

   vce_state_e       state;
   logic [IDX_W-1:0] idx;
   logic             free_found;
   logic [IDX_W-1:0] free_idx;

   logic              cur_valid;
   logic [VID_W-1:0]  cur_vid;
   logic [MEMB_W-1:0] cur_memb;
   logic              cur_hit;
   logic              at_last;
   logic              port_ok;
   logic              done;
   logic              to_commit;

   assign cur_valid = ent_valid[idx];
   assign cur_vid   = ent_vid[idx];
   assign cur_memb  = ent_memb[idx];
   assign cur_hit   = cur_valid && (cur_vid == cmd_vid);
   assign at_last   = (idx == LAST_IDX);
   assign port_ok   = ({1'b0, cmd_port} < PORT_LIM);
   assign busy      = (state != ST_IDLE);

   always_comb begin
      wr_en     = 1'b0;
      wr_idx    = idx;
      wr_valid  = cur_valid;
      wr_vid    = cur_vid;
      wr_memb   = cur_memb;
      done      = 1'b0;
      to_commit = 1'b0;
      unique case (state)
         ST_WALK: begin
            case (cmd_op)
               OP_FLUSH: begin
                  wr_en    = 1'b1;
                  wr_valid = 1'b0;
                  wr_vid   = '0;
                  wr_memb  = '0;
                  done     = at_last;
               end
               OP_LOAD: begin
                  if (cur_hit) begin
                     wr_en    = 1'b1;
                     wr_valid = 1'b1;
                     wr_memb  = data_memb;
                     done     = 1'b1;
                  end else begin
                     to_commit = at_last;
                  end
               end
               OP_PURGE: begin
                  if (cur_hit) begin
                     wr_en    = 1'b1;
                     wr_valid = 1'b0;
                     done     = 1'b1;
                  end else begin
                     done = at_last;
                  end
               end
               OP_RMPORT: begin
                  if (port_ok) begin
                     wr_en   = 1'b1;
                     wr_memb = cur_memb & ~(MEMB_W'(1) << cmd_port);
                  end
                  done = at_last;
               end
               default: done = 1'b1;
            endcase
         end
         ST_COMMIT: begin
            if (free_found) begin
               wr_en    = 1'b1;
               wr_idx   = free_idx;
               wr_valid = 1'b1;
               wr_vid   = cmd_vid;
               wr_memb  = data_memb;
            end
            done = 1'b1;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         idx        <= '0;
         free_found <= 1'b0;
         free_idx   <= '0;
         full       <= 1'b0;
      end else if (start) begin
         state      <= ST_WALK;
         idx        <= '0;
         free_found <= 1'b0;
         free_idx   <= '0;
         full       <= 1'b0;
      end else begin
         unique case (state)
            ST_WALK: begin
               if (cmd_op == OP_LOAD && !cur_valid && !free_found) begin
                  free_found <= 1'b1;
                  free_idx   <= idx;
               end
               if (done)           state <= ST_IDLE;
               else if (to_commit) state <= ST_COMMIT;
               else                idx   <= idx + 1'b1;
            end
            ST_COMMIT: begin
               if (!free_found) full <= 1'b1;
               state <= ST_IDLE;
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/vce_lookup.sv
module vce_lookup #(
   parameter int DEPTH  = 16,
   parameter int VID_W  = 12,
   parameter int MEMB_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [VID_W-1:0]  lookup_vid,
   input  logic [DEPTH-1:0]  ent_valid,
   input  logic [VID_W-1:0]  ent_vid  [DEPTH],
   input  logic [MEMB_W-1:0] ent_memb [DEPTH],
   output logic              lookup_hit,
   output logic [MEMB_W-1:0] lookup_members
);

   logic [DEPTH-1:0]  match;
   logic [MEMB_W-1:0] pick;

   for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
      assign match[g] = ent_valid[g] && (ent_vid[g] == lookup_vid);
   end

   always_comb begin
      pick = '0;
      for (int i = DEPTH - 1; i >= 0; i--) begin
         if (match[i]) pick = ent_memb[i];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lookup_hit     <= 1'b0;
         lookup_members <= '0;
      end else begin
         lookup_hit     <= |match;
         lookup_members <= pick;
      end
   end

endmodule

// File: rtl/vlan_cmd_engine.sv
module vlan_cmd_engine
   import vce_pkg::*;
#(
   parameter int DEPTH  = 16,
   parameter int VID_W  = 12,
   parameter int MEMB_W = 10,
   parameter int PORT_W = 4,
   parameter int PRIO_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic [VID_W-1:0]  lookup_vid,
   output logic              lookup_hit,
   output logic [MEMB_W-1:0] lookup_members
);

   localparam int IDX_W = $clog2(DEPTH);

   if (DEPTH < 2)               begin : g_bad_depth  $error("DEPTH must be at least 2");       end
   if (VID_W < 1 || VID_W > 12) begin : g_bad_vid    $error("VID_W must be 1..12");            end
   if (MEMB_W < 1 || MEMB_W > 11) begin : g_bad_memb $error("MEMB_W must be 1..11");           end
   if (PORT_W < 1 || PORT_W > 4) begin : g_bad_port  $error("PORT_W must be 1..4");            end
   if (PRIO_W < 1 || PRIO_W > 3) begin : g_bad_prio  $error("PRIO_W must be 1..3");            end
   if (MEMB_W > (1 << PORT_W))  begin : g_bad_reach  $error("PORT_W too narrow for MEMB_W");   end

   logic              start;
   logic              busy;
   logic              full;
   logic [2:0]        cmd_op;
   logic [PORT_W-1:0] cmd_port;
   logic [VID_W-1:0]  cmd_vid;
   logic [MEMB_W-1:0] data_memb;

   logic              wr_en;
   logic [IDX_W-1:0]  wr_idx;
   logic              wr_valid;
   logic [VID_W-1:0]  wr_vid;
   logic [MEMB_W-1:0] wr_memb;

   logic [DEPTH-1:0]  ent_valid;
   logic [VID_W-1:0]  ent_vid  [DEPTH];
   logic [MEMB_W-1:0] ent_memb [DEPTH];

   vce_regs #(
      .VID_W(VID_W), .MEMB_W(MEMB_W), .PORT_W(PORT_W), .PRIO_W(PRIO_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .busy(busy), .full(full),
      .reg_rdata(reg_rdata), .start(start),
      .cmd_op(cmd_op), .cmd_port(cmd_port), .cmd_vid(cmd_vid),
      .data_memb(data_memb)
   );

   vce_walker #(
      .DEPTH(DEPTH), .VID_W(VID_W), .MEMB_W(MEMB_W), .PORT_W(PORT_W)
   ) u_walker (
      .clk(clk), .rst_n(rst_n), .start(start),
      .cmd_op(cmd_op), .cmd_port(cmd_port), .cmd_vid(cmd_vid),
      .data_memb(data_memb),
      .ent_valid(ent_valid), .ent_vid(ent_vid), .ent_memb(ent_memb),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_valid(wr_valid),
      .wr_vid(wr_vid), .wr_memb(wr_memb),
      .busy(busy), .full(full)
   );

   vce_table #(
      .DEPTH(DEPTH), .VID_W(VID_W), .MEMB_W(MEMB_W)
   ) u_table (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_valid(wr_valid),
      .wr_vid(wr_vid), .wr_memb(wr_memb),
      .ent_valid(ent_valid), .ent_vid(ent_vid), .ent_memb(ent_memb)
   );

   vce_lookup #(
      .DEPTH(DEPTH), .VID_W(VID_W), .MEMB_W(MEMB_W)
   ) u_lookup (
      .clk(clk), .rst_n(rst_n), .lookup_vid(lookup_vid),
      .ent_valid(ent_valid), .ent_vid(ent_vid), .ent_memb(ent_memb),
      .lookup_hit(lookup_hit), .lookup_members(lookup_members)
   );

endmodule

// File: rtl/vce_checker.sv
module vce_checker
   import vce_pkg::*;
#(
   parameter int DEPTH  = 16,
   parameter int VID_W  = 12,
   parameter int MEMB_W = 10
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr,
   input logic              reg_addr,
   input logic [31:0]       reg_wdata,
   input logic              busy,
   input logic              full,
   input logic [2:0]        cmd_op,
   input logic [VID_W-1:0]  cmd_vid,
   input logic [DEPTH-1:0]  ent_valid,
   input logic              lookup_hit,
   input logic [MEMB_W-1:0] lookup_members
);

   int unsigned run_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    run_cnt <= 0;
      else if (busy) run_cnt <= run_cnt + 1;
      else           run_cnt <= 0;
   end

   // R2: a start write while idle makes the engine busy on the next cycle
   p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && !reg_addr && reg_wdata[CMD_BUSY_BIT] && !busy) |=> busy);

   // R4: a register write during a walk leaves the latched identifier alone
   p_busy_write_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && reg_wr) |=> $stable(cmd_vid));

   // R5: when a flush completes no entry is valid
   p_flush_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(busy) && cmd_op == OP_FLUSH) |-> (ent_valid == '0));

   // R7: no operation stays busy longer than a full walk plus a commit cycle
   p_busy_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (run_cnt <= DEPTH));

   // R8: full only rises at the end of a load
   p_full_from_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(full) |-> (cmd_op == OP_LOAD && !busy));

   // R12: a miss returns a zero member mask
   p_miss_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !lookup_hit |-> (lookup_members == '0));

endmodule

bind vlan_cmd_engine vce_checker #(
   .DEPTH(DEPTH), .VID_W(VID_W), .MEMB_W(MEMB_W)
) u_vce_checker (
   .clk(clk), .rst_n(rst_n),
   .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
   .busy(busy), .full(full), .cmd_op(cmd_op), .cmd_vid(cmd_vid),
   .ent_valid(ent_valid),
   .lookup_hit(lookup_hit), .lookup_members(lookup_members)
);

// File: tb/vlan_cmd_engine_test.sv
module vlan_cmd_engine_test;

   localparam int DEPTH  = 16;
   localparam int VID_W  = 12;
   localparam int MEMB_W = 10;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              reg_wr = 1'b0;
   logic              reg_addr = 1'b0;
   logic [31:0]       reg_wdata = '0;
   logic [31:0]       reg_rdata;
   logic [VID_W-1:0]  lookup_vid = '0;
   logic              lookup_hit;
   logic [MEMB_W-1:0] lookup_members;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   bit ended  = 0;

   always #10 clk = ~clk;

   vlan_cmd_engine uut (
      .clk(clk), .rst_n(rst_n),
      .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata),
      .lookup_vid(lookup_vid), .lookup_hit(lookup_hit),
      .lookup_members(lookup_members)
   );

   // ---------------- reference model ----------------
   logic              m_valid [DEPTH];
   logic [VID_W-1:0]  m_vid   [DEPTH];
   logic [MEMB_W-1:0] m_memb  [DEPTH];
   logic [MEMB_W-1:0] m_data;
   logic              m_full;

   function automatic int model_exec(input logic [2:0] op, input logic [3:0] port,
                                     input logic [VID_W-1:0] vid);
      m_full = 1'b0;
      case (op)
         3'd1: begin
            for (int i = 0; i < DEPTH; i++) m_valid[i] = 1'b0;
            return DEPTH;
         end
         3'd2: begin
            for (int i = 0; i < DEPTH; i++)
               if (m_valid[i] && m_vid[i] == vid) begin
                  m_memb[i] = m_data;
                  return i + 1;
               end
            for (int i = 0; i < DEPTH; i++)
               if (!m_valid[i]) begin
                  m_valid[i] = 1'b1; m_vid[i] = vid; m_memb[i] = m_data;
                  return DEPTH + 1;
               end
            m_full = 1'b1;
            return DEPTH + 1;
         end
         3'd3: begin
            for (int i = 0; i < DEPTH; i++)
               if (m_valid[i] && m_vid[i] == vid) begin
                  m_valid[i] = 1'b0;
                  return i + 1;
               end
            return DEPTH;
         end
         3'd4: begin
            if (int'(port) < MEMB_W)
               for (int i = 0; i < DEPTH; i++) m_memb[i][port] = 1'b0;
            return DEPTH;
         end
         default: return 1;
      endcase
   endfunction

   function automatic logic [MEMB_W:0] model_lookup(input logic [VID_W-1:0] vid);
      for (int i = 0; i < DEPTH; i++)
         if (m_valid[i] && m_vid[i] == vid) return {1'b1, m_memb[i]};
      return '0;
   endfunction

   function automatic logic [31:0] mk_cmd(input logic [2:0] op, input logic [3:0] port,
                                          input logic [11:0] vid, input logic [2:0] prio,
                                          input logic pe);
      return {pe, prio, vid, 4'b0, port, 3'b0, 1'b0, 1'b1, op};
   endfunction

   // ---------------- bench tasks ----------------
   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic reg_write(input logic a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic reg_read(input logic a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic wait_idle(output int n);
      n = 0;
      reg_addr = 1'b0;
      #1;
      while (reg_rdata[3] && n < 100) begin
         @(negedge clk); #1;
         n++;
      end
   endtask

   task automatic write_data(input logic [31:0] d);
      reg_write(1'b1, d);
      m_data = d[MEMB_W-1:0];
   endtask

   task automatic do_cmd(input string req, input logic [2:0] op, input logic [3:0] port,
                         input logic [VID_W-1:0] vid);
      int n;
      int exp_n;
      logic [31:0] rd;
      exp_n = model_exec(op, port, vid);
      reg_write(1'b0, mk_cmd(op, port, vid, 3'd0, 1'b0));
      wait_idle(n);
      check(req, "busy cycles", n, exp_n);
      reg_read(1'b0, rd);
      check(req, "full flag", {31'b0, rd[4]}, {31'b0, m_full});
   endtask

   task automatic lk_check(input string req, input logic [VID_W-1:0] vid);
      logic [MEMB_W:0] e;
      @(negedge clk);
      lookup_vid = vid;
      @(negedge clk); #1;
      e = model_lookup(vid);
      check(req, "lookup", {21'b0, lookup_hit, lookup_members}, {21'b0, e});
   endtask

   // ---------------- watchdog ----------------
   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !ended) begin
         ended = 1;
         fails++;
         $display("FAIL watchdog actual=%0d expected<150000 cycles", cyc);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

   // ---------------- stimulus ----------------
   initial begin
      logic [31:0] rd;
      int n;
      logic [VID_W-1:0] pool [24];
      void'($urandom(32'd20240611));
      for (int i = 0; i < 24; i++) pool[i] = VID_W'(12'h040 + i * 7);
      for (int i = 0; i < DEPTH; i++) begin
         m_valid[i] = 1'b0; m_vid[i] = '0; m_memb[i] = '0;
      end
      m_data = '0; m_full = 1'b0;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      reg_read(1'b0, rd); check("R1", "cmd reg", rd, 32'h0);
      reg_read(1'b1, rd); check("R1", "data reg", rd, 32'h0);
      lk_check("R1", 12'h000);

      // R3: data register field masking
      write_data(32'hFFFF_FFFF);
      reg_read(1'b1, rd); check("R3", "data readback", rd, 32'h0000_0BFF);

      // R2: write without start bit while idle is ignored
      reg_write(1'b0, 32'h1234_5602);
      reg_read(1'b0, rd); check("R2", "no-start write", rd, 32'h0);

      // R5: flush
      do_cmd("R5", 3'd1, 4'd0, 12'h000);

      // R7: new identifiers go to lowest free slots
      write_data(32'h0000_0805);
      do_cmd("R7", 3'd2, 4'd0, 12'h100);
      lk_check("R7", 12'h100);
      write_data(32'h0000_000A);
      do_cmd("R7", 3'd2, 4'd0, 12'h200);
      // R6: reload matching entry at index 1 -> 2 cycles
      write_data(32'h0000_00F0);
      do_cmd("R6", 3'd2, 4'd0, 12'h200);
      lk_check("R6", 12'h200);

      // R2: full field readback of a latched command
      begin
         int xn;
         void'(model_exec(3'd2, 4'd3, 12'h200));
         reg_write(1'b0, mk_cmd(3'd2, 4'd3, 12'h200, 3'd5, 1'b1));
         wait_idle(xn);
         reg_read(1'b0, rd);
         check("R2", "cmd readback", rd, mk_cmd(3'd2, 4'd3, 12'h200, 3'd5, 1'b1) & ~32'h8);
      end

      // R4 + R10: writes during a remove-port walk with port 12 are ignored
      reg_write(1'b0, mk_cmd(3'd4, 4'd12, 12'h300, 3'd0, 1'b0));
      void'(model_exec(3'd4, 4'd12, 12'h300));
      reg_write(1'b1, 32'h0000_03FF);
      reg_write(1'b0, mk_cmd(3'd2, 4'd0, 12'h777, 3'd0, 1'b0));
      wait_idle(n);
      reg_read(1'b1, rd); check("R4", "data kept", rd, {20'b0, 1'b0, 1'b0, m_data});
      reg_read(1'b0, rd); check("R4", "cmd vid kept", {20'b0, rd[27:16]}, 32'h300);
      lk_check("R10", 12'h100);
      lk_check("R4", 12'h777);

      // R10: remove port 0
      do_cmd("R10", 3'd4, 4'd0, 12'h000);
      lk_check("R10", 12'h100);

      // R9: purge hit at index 1 and purge miss
      do_cmd("R9", 3'd3, 4'd0, 12'h200);
      lk_check("R9", 12'h200);
      do_cmd("R9", 3'd3, 4'd0, 12'h999);
      lk_check("R9", 12'h100);

      // R11: no-op and an undefined code
      do_cmd("R11", 3'd0, 4'd0, 12'h100);
      do_cmd("R11", 3'd6, 4'd5, 12'h100);
      lk_check("R11", 12'h100);

      // R8: fill the table then overflow
      do_cmd("R8", 3'd1, 4'd0, 12'h000);
      for (int i = 0; i < DEPTH; i++) begin
         write_data(32'(i + 1));
         do_cmd("R7", 3'd2, 4'd0, VID_W'(12'h500 + i));
      end
      write_data(32'h0000_0155);
      do_cmd("R8", 3'd2, 4'd0, 12'h6AA);
      lk_check("R8", 12'h6AA);
      lk_check("R8", 12'h50F);
      do_cmd("R8", 3'd0, 4'd0, 12'h000);

      // R12: lookup racing a purge of slot 0
      lookup_vid = 12'h500;
      void'(model_exec(3'd3, 4'd0, 12'h500));
      reg_write(1'b0, mk_cmd(3'd3, 4'd0, 12'h500, 3'd0, 1'b0));
      @(negedge clk); #1;
      check("R12", "pre-update lookup", {21'b0, lookup_hit, lookup_members}, {21'b0, 1'b1, 10'd1});
      reg_addr = 1'b0; #1;
      check("R9", "purge idx0 done", {31'b0, reg_rdata[3]}, 32'h0);
      @(negedge clk); #1;
      check("R12", "post-update lookup", {21'b0, lookup_hit, lookup_members}, 32'h0);

      // random phase
      do_cmd("R5", 3'd1, 4'd0, 12'h000);
      for (int it = 0; it < 200; it++) begin
         int r;
         logic [VID_W-1:0] v;
         r = int'($urandom % 20);
         v = pool[$urandom % 24];
         if (r < 10) begin
            write_data(32'($urandom % 1024) | 32'h800);
            do_cmd("R6", 3'd2, 4'd0, v);
         end else if (r < 14) begin
            do_cmd("R9", 3'd3, 4'd0, v);
         end else if (r < 17) begin
            do_cmd("R10", 3'd4, 4'($urandom % 16), v);
         end else if (r < 18) begin
            do_cmd("R5", 3'd1, 4'd0, v);
         end else begin
            logic [2:0] odd [4];
            odd[0] = 3'd0; odd[1] = 3'd5; odd[2] = 3'd6; odd[3] = 3'd7;
            do_cmd("R11", odd[$urandom % 4], 4'd0, v);
         end
         lk_check("R12", pool[$urandom % 24]);
         lk_check("R12", v);
      end

      ended = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

endmodule